// File: doc/BRIEF.md
# Swizzling Vector Register File

This block is the temporary register storage of a shader-style vector datapath. It holds 32 registers. Each register has four 32-bit components, named x, y, z and w, or equally r, g, b and a. Components are treated as IEEE-754 single-precision words. The block has no arithmetic, constant storage, texture sampling or instruction decode. It only stores vectors and presents them to an execution unit in the shape an instruction asks for.

Two independent read ports each take a register index, an 8-bit swizzle code and a negate flag. The swizzle lets each output lane take any source component, so patterns such as .zzzz or .xxyz are possible. The negate flag flips the sign of every delivered component. Both operations sit in the combinational read path, so a read costs no extra cycle. A single write port takes an index, a 4-bit lane enable and a 128-bit vector. Only the enabled components of the addressed register change.

Top module: `swizzle_vrf`

## Requirements
- R1: A vector on any data port packs lane x in bits [31:0], y in [63:32], z in [95:64] and w in [127:96]. A full write followed by an identity read returns the same 128 bits.
- R2: There are 32 registers, selected by a 5-bit index. Writing one register leaves the other 31 unchanged.
- R3: The swizzle code holds one 2-bit field per output lane: bits [1:0] for lane x, [3:2] for y, [5:4] for z and [7:6] for w. A field value of 0, 1, 2 or 3 selects source component x, y, z or w. Code 8'hE4 is the identity.
- R4: A swizzle may pick the same source component for several output lanes, for example .zzzz (8'hAA) or .xxyz (8'h90).
- R5: When the negate flag is 1, bit 31 of each delivered component is inverted and all other bits are unchanged. When the flag is 0, the value passes through as is.
- R6: Read data depends combinationally on the index, swizzle and negate inputs and on the current contents. A change to any of them shows up in the same cycle.
- R7: Write-mask bit 0 enables x, bit 1 y, bit 2 z and bit 3 w. At a clock edge only the enabled components of the addressed register take the new data. The others keep their values.
- R8: A write mask of 4'b0000 changes no register.
- R9: A write appears on the read ports only after the clock edge that performs it. A read of the same register in the write's cycle returns the old contents.
- R10: A synchronous active-high reset sets every component of every register to zero.
- R11: The two read ports are independent. They may read the same or different registers with different swizzle and negate settings in the same cycle, and each returns the value its own settings define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| rd0_idx | input | 5 | Register index for read port 0 |
| rd0_swz | input | 8 | Swizzle code for read port 0 |
| rd0_neg | input | 1 | Negate flag for read port 0 |
| rd0_data | output | 128 | Swizzled and optionally negated vector from read port 0 |
| rd1_idx | input | 5 | Register index for read port 1 |
| rd1_swz | input | 8 | Swizzle code for read port 1 |
| rd1_neg | input | 1 | Negate flag for read port 1 |
| rd1_data | output | 128 | Swizzled and optionally negated vector from read port 1 |
| wr_idx | input | 5 | Register index for the write port |
| wr_mask | input | 4 | Per-component write enable, bit 0 = x, bit 3 = w |
| wr_data | input | 128 | Vector to write, lane x in the low word |

## Verification
The bench reads one register on each port with all 256 swizzle codes, both with and without negation. A swapped field order or a wrong field-to-lane mapping would therefore show up as misplaced words. A negate that touches more than the sign bit would corrupt mantissas or exponents. It also writes one register with all 16 write masks against a running model. A mask bit order that is reversed, or a write to the whole vector, would change components that should hold, and a zero mask that still wrote would overwrite data. It checks that a same-cycle read returns the old contents before the clock edge and the new ones after it, which would catch a bypass that was added or a write that takes effect late. It also drives the two ports with conflicting settings on one register, which would expose select lines that the ports share.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  localparam int LANES = 4;
  localparam int SEL_W = $clog2(LANES);
  localparam int SWZ_W = LANES * SEL_W;
  localparam logic [SWZ_W-1:0] SWZ_IDENTITY = 8'hE4;

  typedef enum logic [SEL_W-1:0] {
    LANE_X = 2'd0,
    LANE_Y = 2'd1,
    LANE_Z = 2'd2,
    LANE_W = 2'd3
  } lane_e;

  // Source component chosen for one output lane by a swizzle code.
  function automatic lane_e swz_field(input logic [SWZ_W-1:0] code, input int lane);
    return lane_e'(code[lane*SEL_W +: SEL_W]);
  endfunction

endpackage

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int NUM_REGS = 32,
  parameter int COMP_W   = 32,
  parameter int LANES    = 4,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int VEC_W   = LANES * COMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LANES-1:0] wr_mask,
  input  logic [VEC_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [VEC_W-1:0] row_a,
  output logic [VEC_W-1:0] row_b
);

  // One storage column per component lane; each column has its own enable.
  for (genvar l = 0; l < LANES; l++) begin : g_col
    logic [COMP_W-1:0] col_mem [NUM_REGS];
    logic              col_we;

    assign col_we = wr_mask[l];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int r = 0; r < NUM_REGS; r++) begin
          col_mem[r] <= '0;
        end
      end else if (col_we) begin
        col_mem[wr_idx] <= wr_data[l*COMP_W +: COMP_W];
      end
    end

    assign row_a[l*COMP_W +: COMP_W] = col_mem[rd_idx_a];
    assign row_b[l*COMP_W +: COMP_W] = col_mem[rd_idx_b];
  end

endmodule

// File: rtl/vrf_swizzle_port.sv
module vrf_swizzle_port
  import vrf_pkg::*;
#(
  parameter int COMP_W = 32,
  localparam int VEC_W = LANES * COMP_W
) (
  input  logic [VEC_W-1:0] row,
  input  logic [SWZ_W-1:0] swz,
  input  logic             neg,
  output logic [VEC_W-1:0] data
);

  // Sign inversion of one floating-point word; only the top bit moves.
  function automatic logic [COMP_W-1:0] apply_sign(input logic [COMP_W-1:0] v, input logic flip);
    logic [COMP_W-1:0] r;
    r = v;
    r[COMP_W-1] = v[COMP_W-1] ^ flip;
    return r;
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_e             src_sel;
    logic [COMP_W-1:0] picked;

    assign src_sel = swz_field(swz, l);

    always_comb begin
      picked = '0;
      for (int s = 0; s < LANES; s++) begin
        if (int'(src_sel) == s) begin
          picked = row[s*COMP_W +: COMP_W];
        end
      end
    end

    assign data[l*COMP_W +: COMP_W] = apply_sign(picked, neg);
  end

endmodule

// File: rtl/swizzle_vrf.sv
module swizzle_vrf
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int COMP_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int VEC_W   = LANES * COMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [SWZ_W-1:0] rd0_swz,
  input  logic             rd0_neg,
  output logic [VEC_W-1:0] rd0_data,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [SWZ_W-1:0] rd1_swz,
  input  logic             rd1_neg,
  output logic [VEC_W-1:0] rd1_data,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LANES-1:0] wr_mask,
  input  logic [VEC_W-1:0] wr_data
);

  // Unswizzled rows, brought out as named wires for the checker.
  logic [VEC_W-1:0] raw_row0;
  logic [VEC_W-1:0] raw_row1;

  vrf_bank #(
    .NUM_REGS (NUM_REGS),
    .COMP_W   (COMP_W),
    .LANES    (LANES)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_idx   (wr_idx),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .rd_idx_a (rd0_idx),
    .rd_idx_b (rd1_idx),
    .row_a    (raw_row0),
    .row_b    (raw_row1)
  );

  vrf_swizzle_port #(.COMP_W(COMP_W)) u_port0 (
    .row  (raw_row0),
    .swz  (rd0_swz),
    .neg  (rd0_neg),
    .data (rd0_data)
  );

  vrf_swizzle_port #(.COMP_W(COMP_W)) u_port1 (
    .row  (raw_row1),
    .swz  (rd1_swz),
    .neg  (rd1_neg),
    .data (rd1_data)
  );

endmodule

// File: rtl/swizzle_vrf_chk.sv
module swizzle_vrf_chk #(
  parameter int COMP_W = 32,
  parameter int IDX_W  = 5,
  parameter int LANES  = 4,
  parameter int SWZ_W  = 8,
  localparam int VEC_W = LANES * COMP_W
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] rd0_idx,
  input logic [SWZ_W-1:0] rd0_swz,
  input logic             rd0_neg,
  input logic [VEC_W-1:0] rd0_data,
  input logic [IDX_W-1:0] rd1_idx,
  input logic [SWZ_W-1:0] rd1_swz,
  input logic             rd1_neg,
  input logic [VEC_W-1:0] rd1_data,
  input logic [IDX_W-1:0] wr_idx,
  input logic [LANES-1:0] wr_mask,
  input logic [VEC_W-1:0] wr_data,
  input logic [VEC_W-1:0] row0
);

  logic past_rst;
  always_ff @(posedge clk) past_rst <= rst;

  logic [VEC_W-1:0] sign_bits;
  always_comb begin
    sign_bits = '0;
    for (int l = 0; l < LANES; l++) sign_bits[l*COMP_W + COMP_W - 1] = 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) (past_rst && !rst) |-> (row0 == '0)); // R10

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wr_mask == '0) |=> (!$stable(rd0_idx) || $stable(row0))); // R8

  AST_PORT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == rd1_idx && rd0_swz == rd1_swz && rd0_neg == rd1_neg) |-> (rd0_data == rd1_data)); // R11

  AST_NEG_PAIR: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == rd1_idx && rd0_swz == rd1_swz && rd0_neg != rd1_neg) |-> ((rd0_data ^ rd1_data) == sign_bits)); // R5

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!wr_mask[k] && wr_idx == rd0_idx) |=>
      (!$stable(rd0_idx) || row0[k*COMP_W +: COMP_W] == $past(row0[k*COMP_W +: COMP_W]))); // R7

    AST_LANE_LAND: assert property (@(posedge clk) disable iff (rst)
      (wr_mask[k] && wr_idx == rd0_idx) |=>
      (!$stable(rd0_idx) || row0[k*COMP_W +: COMP_W] == $past(wr_data[k*COMP_W +: COMP_W]))); // R9
  end

endmodule

bind swizzle_vrf swizzle_vrf_chk #(
  .COMP_W (COMP_W),
  .IDX_W  (IDX_W),
  .LANES  (vrf_pkg::LANES),
  .SWZ_W  (vrf_pkg::SWZ_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd0_idx  (rd0_idx),
  .rd0_swz  (rd0_swz),
  .rd0_neg  (rd0_neg),
  .rd0_data (rd0_data),
  .rd1_idx  (rd1_idx),
  .rd1_swz  (rd1_swz),
  .rd1_neg  (rd1_neg),
  .rd1_data (rd1_data),
  .wr_idx   (wr_idx),
  .wr_mask  (wr_mask),
  .wr_data  (wr_data),
  .row0     (raw_row0)
);

// File: tb/swizzle_vrf_tb.sv
module swizzle_vrf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int CW   = 32;
  localparam int VW   = 4 * CW;
  localparam int WATCHDOG_CYCLES = 100000;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    rd0_idx, rd1_idx, wr_idx;
  logic [7:0]    rd0_swz, rd1_swz;
  logic          rd0_neg, rd1_neg;
  logic [VW-1:0] rd0_data, rd1_data, wr_data;
  logic [3:0]    wr_mask;

  logic [CW-1:0] model [NREG][4];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swizzle_vrf u_dut (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_swz(rd0_swz), .rd0_neg(rd0_neg), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_swz(rd1_swz), .rd1_neg(rd1_neg), .rd1_data(rd1_data),
    .wr_idx(wr_idx), .wr_mask(wr_mask), .wr_data(wr_data)
  );

  // Expected read value: each output lane takes the component named by its
  // 2-bit field; a negated word has 2^31 added modulo 2^32.
  function automatic logic [VW-1:0] expect_read(int r, logic [7:0] swz, logic neg);
    logic [VW-1:0] res;
    for (int i = 0; i < 4; i++) begin
      int src;
      logic [CW-1:0] v;
      src = (int'(swz) / (1 << (2*i))) % 4;
      v = model[r][src];
      if (neg) v = v + 32'h8000_0000;
      res[i*CW +: CW] = v;
    end
    return res;
  endfunction

  function automatic logic [CW-1:0] pattern(int r, int l);
    logic [CW-1:0] v;
    v = 32'h1000_0000 * (l + 1) + 32'h0001_0101 * r + 32'd7 * l;
    if (r % 4 >= 2) v = v ^ 32'h8000_0000;
    return v;
  endfunction

  task automatic check(string req, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(int r, logic [3:0] m, logic [VW-1:0] d);
    @(negedge clk);
    wr_idx = 5'(r); wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_mask = 4'b0000;
    for (int l = 0; l < 4; l++) if (m[l]) model[r][l] = d[l*CW +: CW];
  endtask

  task automatic read_check(int port, int r, logic [7:0] swz, logic neg, string req, string what);
    if (port == 0) begin
      rd0_idx = 5'(r); rd0_swz = swz; rd0_neg = neg;
      #1 check(req, what, rd0_data, expect_read(r, swz, neg));
    end else begin
      rd1_idx = 5'(r); rd1_swz = swz; rd1_neg = neg;
      #1 check(req, what, rd1_data, expect_read(r, swz, neg));
    end
  endtask

  function automatic bit has_repeat(logic [7:0] s);
    return (s[1:0] == s[3:2]) || (s[1:0] == s[5:4]) || (s[1:0] == s[7:6]) ||
           (s[3:2] == s[5:4]) || (s[3:2] == s[7:6]) || (s[5:4] == s[7:6]);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    rd0_idx = '0; rd1_idx = '0; wr_idx = '0;
    rd0_swz = 8'hE4; rd1_swz = 8'hE4; rd0_neg = 1'b0; rd1_neg = 1'b0;
    wr_mask = '0; wr_data = '0;
    for (int r = 0; r < NREG; r++) for (int l = 0; l < 4; l++) model[r][l] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: everything reads zero after reset
    for (int r = 0; r < NREG; r++) begin
      read_check(0, r, 8'hE4, 1'b0, "R10", "reset port0");
      read_check(1, r, 8'h1B, 1'b0, "R10", "reset port1");
    end

    // R2 / R1: fill every register, then identity readback on both ports
    for (int r = 0; r < NREG; r++) begin
      do_write(r, 4'hF, {pattern(r,3), pattern(r,2), pattern(r,1), pattern(r,0)});
    end
    for (int r = 0; r < NREG; r++) begin
      read_check(0, r, 8'hE4, 1'b0, "R1", "identity port0");
      read_check(1, r, 8'hE4, 1'b0, "R2", "identity port1");
    end

    // R3 / R4 / R5: full swizzle and negate sweep on each port
    for (int s = 0; s < 256; s++) begin
      for (int n = 0; n < 2; n++) begin
        string req;
        req = (n == 1) ? "R5" : (has_repeat(8'(s)) ? "R4" : "R3");
        read_check(0, 5, 8'(s), n[0], req, "sweep port0");
        read_check(1, 18, 8'(s), n[0], req, "sweep port1");
      end
    end

    // R6: several reads inside one clock period, no edge in between
    @(negedge clk);
    read_check(0, 9, 8'hAA, 1'b0, "R6", "same-cycle read a");
    read_check(0, 22, 8'h90, 1'b1, "R6", "same-cycle read b");
    read_check(0, 9, 8'h1B, 1'b1, "R6", "same-cycle read c");

    // R7 / R8: every write mask on register 7
    for (int m = 0; m < 16; m++) begin
      logic [VW-1:0] d;
      for (int l = 0; l < 4; l++) d[l*CW +: CW] = 32'hC0DE_0000 + 32'(m*16 + l);
      do_write(7, 4'(m), d);
      read_check(0, 7, 8'hE4, 1'b0, (m == 0) ? "R8" : "R7", "masked write");
      read_check(1, 6, 8'hE4, 1'b0, "R7", "neighbour untouched");
    end

    // R9: no write-to-read bypass
    @(negedge clk);
    rd0_idx = 5'd12; rd0_swz = 8'hE4; rd0_neg = 1'b0;
    wr_idx = 5'd12; wr_mask = 4'b0101; wr_data = {4{32'h4049_0FDB}};
    #1 check("R9", "before edge", rd0_data, expect_read(12, 8'hE4, 1'b0));
    @(negedge clk);
    wr_mask = 4'b0000;
    model[12][0] = 32'h4049_0FDB; model[12][2] = 32'h4049_0FDB;
    #1 check("R9", "after edge", rd0_data, expect_read(12, 8'hE4, 1'b0));

    // R11: both ports on one register with conflicting settings
    rd0_idx = 5'd12; rd0_swz = 8'h00; rd0_neg = 1'b1;
    rd1_idx = 5'd12; rd1_swz = 8'hFF; rd1_neg = 1'b0;
    #1;
    check("R11", "port0 of pair", rd0_data, expect_read(12, 8'h00, 1'b1));
    check("R11", "port1 of pair", rd1_data, expect_read(12, 8'hFF, 1'b0));
    read_check(1, 30, 8'h4E, 1'b1, "R11", "port1 other reg");

    // R10: a second reset clears written contents
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < NREG; r++) for (int l = 0; l < 4; l++) model[r][l] = '0;
    read_check(0, 12, 8'hE4, 1'b0, "R10", "after re-reset");
    read_check(1, 31, 8'hE4, 1'b0, "R10", "after re-reset");

    done = 1'b1;
    finish_run();
  end

endmodule